// File: doc/BRIEF.md
# Write-only I2C target with single command register

This block is a receive-only target on a two-wire serial bus. It samples the clock line (SCL) and the data line (SDA) with a much faster system clock. From those samples it finds the bus framing conditions and collects the address byte that follows each start. A data byte sent to its address is stored in one 8-bit command register, and each stored byte is announced with a one-cycle strobe.

The SDA output is open-drain. The block drives only a pull-down enable, which an outside pad or a wired-AND model combines with the line. Transfers addressed for reading are acknowledged, but the block never pulls the line during the data bits that follow, so the controller reads all ones. The 7-bit address is a parameter. The system clock must run at least eight times faster than SCL.

Top module: `wr_i2c_target`

## Requirements
- R1: While reset is held and right after it is released, `sda_pull_o`, `cmd_o` and `cmd_valid_o` are all 0.
- R2: After a START, the first byte is taken MSB first, with the address in bits 7..1 and the direction bit in bit 0 (0 = write). When bits 7..1 equal `TGT_ADDR`, the block holds `sda_pull_o` at 1 through the high phase of the ninth clock.
- R3: When the address does not match, no acknowledge is given. Every following clock is ignored until the next START: no pull-down and no register change.
- R4: In a write transfer, every data byte is acknowledged on its ninth clock and loaded MSB first into `cmd_o`, with `cmd_valid_o` high for exactly one cycle. A later byte in the same transfer replaces the earlier one.
- R5: A matching address with direction bit 1 is acknowledged. After that, `sda_pull_o` stays 0 for all data and acknowledge clocks, so the controller reads 0xFF, and `cmd_o` is not changed.
- R6: A STOP (SDA rising while SCL is high) returns the block to idle at any bit position. A partly received byte is discarded, and clocks without a new START are ignored.
- R7: A STOP that falls within the same SCL-high interval as a START is ignored, and address reception continues.
- R8: A repeated START (SDA falling while SCL is high, with no STOP before it) restarts address reception without leaving the transfer.
- R9: `sda_pull_o` changes only while SCL is low, never during an SCL-high interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level from the pad |
| sda_i | input | 1 | Serial data line level from the pad |
| sda_pull_o | output | 1 | Open-drain pull-down enable for SDA (1 = drive low) |
| cmd_o | output | 8 | Last data byte written to the command register |
| cmd_valid_o | output | 1 | One-cycle strobe when `cmd_o` is loaded |

## Verification
The bench closes the open-drain loop with a wired-AND line model, so acknowledges and read data are seen the way a controller sees them.

It targets several corner cases:
- A START with a STOP in the same SCL-high pulse. A design that honoured that STOP would drop the transfer and give no acknowledge.
- A STOP after four data bits. A design that missed it would go on counting and later load or acknowledge stray clocks.
- A repeated START that switches from writing to reading. A design that got this wrong would keep shifting data or would pull SDA during the read byte.
- Mismatched addresses that differ in the lowest and in the highest address bit. A design that compared the wrong field would acknowledge one of them.

// File: rtl/tgt_i2c_pkg.sv
`timescale 1ns/1ps
package tgt_i2c_pkg;
  localparam int BYTE_BITS = 8;
  localparam int BITCNT_W  = $clog2(BYTE_BITS + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_WRITE = 2'd2,
    ST_READ  = 2'd3
  } tgt_state_e;
endpackage

// File: rtl/tgt_line_sync.sv
`timescale 1ns/1ps
// Synchronises SCL/SDA and derives edge and bus-condition events.
module tgt_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_lvl,
  output logic start_evt,
  output logic stop_evt
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw;
  logic [N_LINES-1:0] cur;
  logic [N_LINES-1:0] prv;
  logic               start_in_pulse;
  logic               stop_raw;

  assign raw = {sda_i, scl_i};

  generate
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
      logic [SYNC_STAGES-1:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[SYNC_STAGES-2:0], raw[g]};
      end
      assign cur[g] = pipe[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prv <= '1;
    else     prv <= cur;
  end

  assign scl_hi    = cur[0];
  assign sda_lvl   = cur[1];
  assign scl_rise  = cur[0] & ~prv[0];
  assign scl_fall  = ~cur[0] & prv[0];
  assign start_evt = cur[0] & prv[0] & prv[1] & ~cur[1];
  assign stop_raw  = cur[0] & prv[0] & ~prv[1] & cur[1];

  // Remembers a START for the rest of the current SCL-high interval.
  always_ff @(posedge clk) begin
    if (rst)            start_in_pulse <= 1'b0;
    else if (!cur[0])   start_in_pulse <= 1'b0;
    else if (start_evt) start_in_pulse <= 1'b1;
  end

  assign stop_evt = stop_raw & ~start_in_pulse;
endmodule

// File: rtl/tgt_frame_fsm.sv
`timescale 1ns/1ps
// Bit counting, address compare and acknowledge generation.
module tgt_frame_fsm
  import tgt_i2c_pkg::*;
#(
  parameter int              ADDR_W   = 7,
  parameter logic [ADDR_W-1:0] TGT_ADDR = 7'h4C
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_hi,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 sda_lvl,
  input  logic                 start_evt,
  input  logic                 stop_evt,
  output logic                 pull_o,
  output logic                 wr_stb_o,
  output logic [BYTE_BITS-1:0] wr_data_o
);
  localparam logic [BITCNT_W-1:0] FULL = BITCNT_W'(BYTE_BITS);

  tgt_state_e           state;
  logic [BITCNT_W-1:0]  cnt;
  logic [BYTE_BITS-1:0] shreg;
  logic                 ack_ph;
  logic                 pull;
  logic                 wr_stb;
  logic [BYTE_BITS-1:0] wr_data;
  logic                 addr_hit;

  assign addr_hit = (shreg[BYTE_BITS-1 -: ADDR_W] == TGT_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      ack_ph  <= 1'b0;
      pull    <= 1'b0;
      wr_stb  <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_evt) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        ack_ph <= 1'b0;
        pull   <= 1'b0;
      end else if (stop_evt) begin
        state  <= ST_IDLE;
        cnt    <= '0;
        ack_ph <= 1'b0;
        pull   <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise && !ack_ph && cnt != FULL) begin
          shreg <= {shreg[BYTE_BITS-2:0], sda_lvl};
          cnt   <= cnt + 1'b1;
        end
        if (scl_fall) begin
          if (ack_ph) begin
            ack_ph <= 1'b0;
            pull   <= 1'b0;
            cnt    <= '0;
          end else if (cnt == FULL) begin
            ack_ph <= 1'b1;
            case (state)
              ST_ADDR: begin
                if (addr_hit) begin
                  pull  <= 1'b1;
                  state <= shreg[0] ? ST_READ : ST_WRITE;
                end else begin
                  state <= ST_IDLE;
                end
              end
              ST_WRITE: begin
                pull    <= 1'b1;
                wr_stb  <= 1'b1;
                wr_data <= shreg;
              end
              default: pull <= 1'b0;
            endcase
          end
        end
      end
    end
  end

  assign pull_o    = pull;
  assign wr_stb_o  = wr_stb;
  assign wr_data_o = wr_data;

  // R9: the pull-down never moves inside an SCL-high interval
  a_r9_pull_quiet_scl_high: assert property (@(posedge clk) disable iff (rst)
    (scl_hi && $past(scl_hi)) |-> $stable(pull));

  // R3: an idle target has released the line
  a_r3_idle_released: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !pull);

  // R5: a read transfer never stores into the command register
  a_r5_read_no_store: assert property (@(posedge clk) disable iff (rst)
    (state == ST_READ) |=> !wr_stb);
endmodule

// File: rtl/tgt_cmd_reg.sv
`timescale 1ns/1ps
// Command register with a one-cycle load strobe.
module tgt_cmd_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] cmd_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] cmd_q;
  logic              valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= load_i;
      if (load_i) cmd_q <= data_i;
    end
  end

  assign cmd_o   = cmd_q;
  assign valid_o = valid_q;

  // R4: the strobe lasts exactly one cycle
  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);

  // R4: the register only changes together with its strobe
  a_r4_cmd_changes_with_valid: assert property (@(posedge clk) disable iff (rst)
    !$stable(cmd_q) |-> valid_q);
endmodule

// File: rtl/wr_i2c_target.sv
`timescale 1ns/1ps
// Write-only two-wire serial target: top level.
module wr_i2c_target
  import tgt_i2c_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR    = 7'h4C,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_pull_o,
  output logic [BYTE_BITS-1:0] cmd_o,
  output logic                 cmd_valid_o
);
  logic                 scl_hi;
  logic                 scl_rise;
  logic                 scl_fall;
  logic                 sda_lvl;
  logic                 start_evt;
  logic                 stop_evt;
  logic                 wr_stb;
  logic [BYTE_BITS-1:0] wr_data;

  tgt_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_hi    (scl_hi),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_lvl   (sda_lvl),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  tgt_frame_fsm #(.ADDR_W(7), .TGT_ADDR(TGT_ADDR)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .scl_hi    (scl_hi),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_lvl   (sda_lvl),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .pull_o    (sda_pull_o),
    .wr_stb_o  (wr_stb),
    .wr_data_o (wr_data)
  );

  tgt_cmd_reg #(.DATA_W(BYTE_BITS)) u_cmd (
    .clk     (clk),
    .rst     (rst),
    .load_i  (wr_stb),
    .data_i  (wr_data),
    .cmd_o   (cmd_o),
    .valid_o (cmd_valid_o)
  );
endmodule

// File: tb/sim_wr_i2c_target.sv
`timescale 1ns/1ps
module sim_wr_i2c_target;
  localparam int Q = 40;
  localparam logic [6:0] ADR = 7'h4C;
  // {addr[24:18], rw[17], data[16:9], exp_ack[8], exp_cmd[7:0]}
  localparam logic [24:0] VEC [6] = '{
    {7'h4C, 1'b0, 8'hA5, 1'b1, 8'hA5},
    {7'h4C, 1'b0, 8'h00, 1'b1, 8'h00},
    {7'h4D, 1'b0, 8'h5A, 1'b0, 8'h00},
    {7'h4C, 1'b1, 8'hFF, 1'b1, 8'h00},
    {7'h0C, 1'b0, 8'h3C, 1'b0, 8'h00},
    {7'h4C, 1'b0, 8'hC3, 1'b1, 8'hC3}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_drv = 1'b1;
  logic       sda_drv = 1'b1;
  logic       sda_line;
  logic       sda_pull_o;
  logic [7:0] cmd_o;
  logic       cmd_valid_o;
  int checks = 0;
  int errors = 0;
  int strobes = 0;
  int pull_viol = 0;
  logic done = 1'b0;
  logic scl_q = 1'b1;
  logic pull_q = 1'b0;

  always #5 clk = ~clk;

  assign sda_line = sda_drv & ~sda_pull_o;

  wr_i2c_target #(.TGT_ADDR(ADR), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .scl_i(scl_drv), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .cmd_o(cmd_o), .cmd_valid_o(cmd_valid_o)
  );

  always @(negedge clk) begin
    if (cmd_valid_o) strobes++;
    if (scl_drv && scl_q && (sda_pull_o != pull_q)) pull_viol++;
    scl_q  <= scl_drv;
    pull_q <= sda_pull_o;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, output logic rd);
    sda_drv = b; #Q;
    scl_drv = 1'b1; #Q;
    rd = sda_line; #Q;
    scl_drv = 1'b0; #Q;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) send_bit(v[i], r);
    send_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic read_byte(output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      send_bit(1'b1, r);
      v[i] = r;
    end
    send_bit(1'b1, r);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; #Q;
    scl_drv = 1'b1; #Q;
    sda_drv = 1'b0; #Q;
    scl_drv = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; #Q;
    scl_drv = 1'b1; #Q;
    sda_drv = 1'b1; #Q;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual=running expected=done");
    finish_run();
  end

  initial begin
    logic       ack;
    logic       ack2;
    logic [7:0] rd;
    int         s0;

    // R1: reset state, during and right after reset
    repeat (4) @(negedge clk);
    chk("R1 pull in reset", {31'd0, sda_pull_o}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 outputs after reset", {23'd0, sda_pull_o, cmd_o, cmd_valid_o}, 32'd0);
    #Q;

    // Vector table walk: R2 address ack, R3 mismatch, R4 store, R5 read
    for (int k = 0; k < 6; k++) begin
      logic [24:0] v;
      v  = VEC[k];
      s0 = strobes;
      bus_start();
      send_byte({v[24:18], v[17]}, ack);
      chk(v[8] ? "R2 address ack" : "R3 mismatch no ack", {31'd0, ack}, {31'd0, v[8]});
      if (!v[17]) begin
        send_byte(v[16:9], ack2);
        chk(v[8] ? "R4 data ack" : "R3 data ignored", {31'd0, ack2}, {31'd0, v[8]});
      end else begin
        read_byte(rd);
        chk("R5 read returns ones", {24'd0, rd}, 32'hFF);
      end
      bus_stop();
      #(4*Q);
      chk("R4 command register", {24'd0, cmd_o}, {24'd0, v[7:0]});
      chk("R4 strobe count", strobes - s0, {31'd0, v[8] & ~v[17]});
    end

    // R4: two bytes in one transfer, the later one wins
    s0 = strobes;
    bus_start();
    send_byte({ADR, 1'b0}, ack);
    send_byte(8'h12, ack);
    chk("R4 first byte ack", {31'd0, ack}, 32'd1);
    send_byte(8'h34, ack);
    chk("R4 second byte ack", {31'd0, ack}, 32'd1);
    bus_stop();
    #(4*Q);
    chk("R4 overwrite", {24'd0, cmd_o}, 32'h34);
    chk("R4 two strobes", strobes - s0, 32'd2);

    // R8 with R5: repeated START switching from write to read
    bus_start();
    send_byte({ADR, 1'b0}, ack);
    send_byte(8'h56, ack);
    bus_start();
    send_byte({ADR, 1'b1}, ack);
    chk("R8 ack after repeated start", {31'd0, ack}, 32'd1);
    read_byte(rd);
    chk("R5 read after repeated start", {24'd0, rd}, 32'hFF);
    bus_stop();
    #(4*Q);
    chk("R8 R5 register kept", {24'd0, cmd_o}, 32'h56);

    // R6: STOP after four data bits, then clocks with no START
    s0 = strobes;
    bus_start();
    send_byte({ADR, 1'b0}, ack);
    send_bit(1'b1, ack2); send_bit(1'b0, ack2);
    send_bit(1'b1, ack2); send_bit(1'b0, ack2);
    bus_stop();
    #(2*Q);
    chk("R6 partial byte dropped", {24'd0, cmd_o}, 32'h56);
    scl_drv = 1'b0; #Q;
    send_byte({ADR, 1'b0}, ack);
    chk("R6 no ack without start", {31'd0, ack}, 32'd0);
    send_byte(8'hE7, ack);
    bus_stop();
    #(4*Q);
    chk("R6 register unchanged", {24'd0, cmd_o}, 32'h56);
    chk("R6 no strobe", strobes - s0, 32'd0);

    // R7: STOP within the same SCL-high pulse as the START
    sda_drv = 1'b1; #Q;
    scl_drv = 1'b1; #Q;
    sda_drv = 1'b0; #Q;
    sda_drv = 1'b1; #Q;
    scl_drv = 1'b0; #Q;
    send_byte({ADR, 1'b0}, ack);
    chk("R7 address ack after masked stop", {31'd0, ack}, 32'd1);
    send_byte(8'h77, ack);
    bus_stop();
    #(4*Q);
    chk("R7 data stored", {24'd0, cmd_o}, 32'h77);

    // R9: pull-down never moved during an SCL-high interval
    chk("R9 pull changes while SCL high", pull_viol, 32'd0);

    finish_run();
  end
endmodule